// File: doc/BRIEF.md
# Privileged Exception Entry Sequencer

This block takes a CPU into privileged mode for two special events: a non-maskable interrupt and a leveled break request from a debugger. While idle, it compares each request against the interrupt level mask held in the program status word (PS). For a break, it also checks the current mode and the debug enable. The interrupt enable flag plays no part in either decision.

Once an event is accepted, the block runs a fixed multi-cycle sequence without re-arbitrating:

1. It publishes an updated PS with privileged mode, the system stack and a new mask level.
2. It pushes the pre-entry PS onto the system stack through a word memory port.
3. It pushes the return address onto the same stack.
4. It reads the handler address from a vector slot relative to the table base register.
5. It ends with a one-cycle completion strobe that loads the program counter (PC) and the stack pointer.

A break entry also raises a debug-state strobe.

The surrounding core owns the PS, SSP, TBR and PC registers. It feeds their values in and applies the write strobes this block produces.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `ps_we`, `mem_req`, `done`, `pc_we`, `ssp_we` and `dbg_enter` are all 0.
- R2: PS layout is UM at bit 31, ILM at bits 20:16, S at bit 5 and the interrupt enable flag at bit 4. An NMI request seen while idle is accepted exactly when ILM is 16 or more, whatever the enable flag holds.
- R3: A break request seen while idle is accepted exactly when `brk_lvl` is numerically below ILM, UM is 1 and `dbg_en` is 1. The enable flag has no effect.
- R4: When an NMI and a break are both acceptable in the same cycle, the NMI entry is performed and `dbg_enter` stays 0.
- R5: In the cycle after acceptance, `ps_we` pulses once. `ps_out` equals the captured PS with UM=0, S=0 and ILM=15 for NMI or ILM=4 for break, with every other bit unchanged.
- R6: The first memory access is a write of the pre-entry PS to SSP-4.
- R7: The second memory access is a write of `next_pc` to SSP-8.
- R8: The third memory access is a read at TBR+0x3C0 for NMI, or at TBR+0x3BC for break.
- R9: Each access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`, and the sequence advances only on an acknowledge.
- R10: After the read is acknowledged, one cycle follows with `done`, `pc_we` and `ssp_we` high. In that cycle `pc_out` is the word read and `ssp_out` is SSP-8. `dbg_enter` is high in that cycle only for a break entry.
- R11: Requests that change during a running sequence neither restart nor alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| brk_req | input | 1 | Debugger break request |
| brk_lvl | input | 5 | Break request level (smaller is stronger) |
| dbg_en | input | 1 | Debugging enabled |
| ps_in | input | 32 | Current program status word |
| ssp_in | input | 32 | Current system stack pointer |
| tbr_in | input | 32 | Vector table base |
| next_pc | input | 32 | Address of the next instruction |
| ps_out | output | 32 | Updated program status word |
| ps_we | output | 1 | Write strobe for `ps_out` |
| ssp_out | output | 32 | Final stack pointer |
| ssp_we | output | 1 | Write strobe for `ssp_out` |
| pc_out | output | 32 | Handler address |
| pc_we | output | 1 | Write strobe for `pc_out` |
| dbg_enter | output | 1 | Enter debug state |
| done | output | 1 | Entry complete |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Access acknowledge |

## Verification
A wrong acceptance decision appears one cycle after the request: `ps_we` either pulses when it should not or stays low. A corrupted captured PS, stack pointer or event kind appears at the port within the next few accesses, as a wrong address or data on the first push, the second push or the vector read. A bad vector capture appears only on `pc_out` in the completion cycle. For this reason the sweep covers every ILM and level pair, and it checks every access of each accepted entry under several acknowledge delays.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] NMI_OFS = 'h3C0,
  parameter logic [XLEN-1:0] BRK_OFS = 'h3BC,
  parameter int UM_BIT = 31,
  parameter int S_BIT = 5,
  parameter int ILM_LSB = 16,
  parameter logic [4:0] NMI_LVL = 5'd15,
  parameter logic [4:0] BRK_ILM = 5'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_req,
  input  logic            brk_req,
  input  logic [4:0]      brk_lvl,
  input  logic            dbg_en,
  input  logic [XLEN-1:0] ps_in,
  input  logic [XLEN-1:0] ssp_in,
  input  logic [XLEN-1:0] tbr_in,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] ps_out,
  output logic            ps_we,
  output logic [XLEN-1:0] ssp_out,
  output logic            ssp_we,
  output logic [XLEN-1:0] pc_out,
  output logic            pc_we,
  output logic            dbg_enter,
  output logic            done,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  typedef enum logic [2:0] {IDLE, STAT, PUSH_PS, PUSH_PC, VEC, FIN} st_t;

  st_t             st;
  logic [XLEN-1:0] sv_ps, sp, npc, vaddr, pc_r;
  logic            is_brk;

  wire [4:0] cur_ilm = ps_in[ILM_LSB +: 5];
  wire nmi_ok = nmi_req && (NMI_LVL < cur_ilm);
  wire brk_ok = brk_req && (brk_lvl < cur_ilm) && ps_in[UM_BIT] && dbg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      sv_ps  <= '0;
      sp     <= '0;
      npc    <= '0;
      vaddr  <= '0;
      pc_r   <= '0;
      is_brk <= 1'b0;
    end else begin
      case (st)
        IDLE: if (nmi_ok || brk_ok) begin
          st     <= STAT;
          sv_ps  <= ps_in;
          sp     <= ssp_in;
          npc    <= next_pc;
          is_brk <= !nmi_ok;
          vaddr  <= tbr_in + (nmi_ok ? NMI_OFS : BRK_OFS);
        end
        STAT: begin
          st <= PUSH_PS;
          sp <= sp - WORD;
        end
        PUSH_PS: if (mem_ack) begin
          st <= PUSH_PC;
          sp <= sp - WORD;
        end
        PUSH_PC: if (mem_ack) st <= VEC;
        VEC: if (mem_ack) begin
          st   <= FIN;
          pc_r <= mem_rdata;
        end
        FIN: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    ps_out = sv_ps;
    ps_out[UM_BIT] = 1'b0;
    ps_out[S_BIT] = 1'b0;
    ps_out[ILM_LSB +: 5] = is_brk ? BRK_ILM : NMI_LVL;
  end

  assign ps_we     = (st == STAT);
  assign busy      = (st != IDLE);
  assign mem_req   = (st == PUSH_PS) || (st == PUSH_PC) || (st == VEC);
  assign mem_we    = (st == PUSH_PS) || (st == PUSH_PC);
  assign mem_addr  = (st == VEC) ? vaddr : sp;
  assign mem_wdata = (st == PUSH_PS) ? sv_ps : (st == PUSH_PC) ? npc : '0;
  assign done      = (st == FIN);
  assign pc_we     = done;
  assign ssp_we    = done;
  assign pc_out    = pc_r;
  assign ssp_out   = sp;
  assign dbg_enter = done && is_brk;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R10
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req && mem_ack && !mem_we));

  // R5
  stat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ps_we && !mem_req);

  // R5
  stat_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_we |-> !ps_out[UM_BIT] && !ps_out[S_BIT]);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ps_we, mem_req, done}));
endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic nmi_req = 0, brk_req = 0, dbg_en = 0;
  logic [4:0] brk_lvl = 0;
  logic [31:0] ps_in = 0, ssp_in = 0, tbr_in = 0, next_pc = 0;
  logic [31:0] ps_out, ssp_out, pc_out, mem_addr, mem_wdata, mem_rdata;
  logic ps_we, ssp_we, pc_we, dbg_enter, done, busy, mem_req, mem_we, mem_ack;

  exc_entry_seq u0 (.*);

  int waits = 0, wcnt = 0, nlog = 0, cyc = 0;
  int tests = 0, fails = 0;
  logic [31:0] la[0:1023];
  logic [31:0] ld[0:1023];
  logic        lw[0:1023];

  assign mem_ack = mem_req && (wcnt == waits);
  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ack) begin
      la[nlog % 1024] <= mem_addr;
      ld[nlog % 1024] <= mem_wdata;
      lw[nlog % 1024] <= mem_we;
      nlog <= nlog + 1;
      wcnt <= 0;
    end else if (mem_req) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run(input bit nmi, input bit brk, input logic [4:0] lvl, input logic [4:0] ilm,
                     input bit um, input bit dbg, input bit ie, input int w, input bit poke);
    logic [31:0] ps, sp0, tb, np, exp_ps;
    bit acc_n, acc_b, acc, got_we, got_done;
    int base, we_at;
    ps = {um, 10'h155, ilm, 10'h2A6, 1'b1, ie, 4'h9};
    sp0 = 32'h0000_8000 + {lvl, 4'h0};
    tb = 32'h0010_0000 + {ilm, 8'h0};
    np = 32'hC000_0000 + {lvl, ilm, 2'b00};
    acc_n = nmi && (ilm > 15);
    acc_b = brk && (lvl < ilm) && um && dbg;
    acc = acc_n || acc_b;
    @(negedge clk);
    waits = w;
    nmi_req = nmi; brk_req = brk; brk_lvl = lvl; dbg_en = dbg;
    ps_in = ps; ssp_in = sp0; tbr_in = tb; next_pc = np;
    base = nlog;
    @(negedge clk);
    nmi_req = 0; brk_req = poke; brk_lvl = 0; dbg_en = poke;
    ps_in = poke ? 32'hFFFF_FFFF : ps; ssp_in = 32'h1234_5678; tbr_in = 0;
    got_we = ps_we; we_at = 0;
    // R2 R3 R11: acceptance visible as ps_we one cycle later
    chk(ps_we == acc, acc_b && !acc_n ? "R3 accept" : "R2 accept", {31'd0, ps_we}, {31'd0, acc});
    if (!acc) begin
      repeat (3) begin
        @(negedge clk);
        chk(!busy && !ps_we && !mem_req, "R2/R3 ignored", {31'd0, busy}, 32'd0);
      end
      return;
    end
    exp_ps = ps; exp_ps[31] = 0; exp_ps[5] = 0; exp_ps[20:16] = acc_n ? 5'd15 : 5'd4;
    // R5
    chk(ps_out == exp_ps, "R5 ps_out", ps_out, exp_ps);
    got_done = 0;
    for (int i = 0; i < 40 && !got_done; i++) begin
      @(negedge clk);
      if (ps_we) chk(0, "R5 second ps_we", 1, 0);
      if (done) begin
        got_done = 1;
        // R10
        chk(pc_we && ssp_we, "R10 strobes", {pc_we, ssp_we}, 2'b11);
        chk(pc_out == ((tb + (acc_n ? 32'h3C0 : 32'h3BC)) ^ 32'hA5A5_0000), "R10 pc_out", pc_out,
            (tb + (acc_n ? 32'h3C0 : 32'h3BC)) ^ 32'hA5A5_0000);
        chk(ssp_out == sp0 - 8, "R10 ssp_out", ssp_out, sp0 - 8);
        // R4 R10
        chk(dbg_enter == !acc_n, acc_n && brk ? "R4 dbg_enter" : "R10 dbg_enter", {31'd0, dbg_enter}, {31'd0, !acc_n});
      end
    end
    brk_req = 0; dbg_en = 0;
    chk(got_done, "R10 done seen", {31'd0, got_done}, 1);
    chk(nlog - base == 3, "R9 access count", nlog - base, 3);
    // R6
    chk(lw[base % 1024] && la[base % 1024] == sp0 - 4 && ld[base % 1024] == ps, "R6 push PS",
        la[base % 1024], sp0 - 4);
    // R7
    chk(lw[(base + 1) % 1024] && la[(base + 1) % 1024] == sp0 - 8 && ld[(base + 1) % 1024] == np, "R7 push PC",
        ld[(base + 1) % 1024], np);
    // R8
    chk(!lw[(base + 2) % 1024] && la[(base + 2) % 1024] == tb + (acc_n ? 32'h3C0 : 32'h3BC), "R8 vector",
        la[(base + 2) % 1024], tb + (acc_n ? 32'h3C0 : 32'h3BC));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !ps_we && !mem_req && !done && !pc_we && !ssp_we && !dbg_enter, "R1 reset idle",
        {25'd0, busy, ps_we, mem_req, done, pc_we, ssp_we, dbg_enter}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy, "R1 idle after release", {31'd0, busy}, 0);
    for (int ilm = 0; ilm < 32; ilm++) begin
      run(1, 0, 0, 5'(ilm), ilm[0], 0, ilm[1], ilm % 3, 0);
      for (int lvl = 0; lvl < 32; lvl++)
        run(0, 1, 5'(lvl), 5'(ilm), 1, 1, lvl[0], (lvl + ilm) % 4, 0);
    end
    // R3: mode and debug gating
    run(0, 1, 0, 31, 0, 1, 0, 0, 0);
    run(0, 1, 0, 31, 1, 0, 1, 0, 0);
    // R4: both pending
    run(1, 1, 0, 20, 1, 1, 0, 1, 0);
    run(1, 1, 3, 16, 1, 1, 1, 2, 0);
    // R11: break held asserted during an NMI sequence
    run(1, 0, 0, 31, 1, 1, 0, 2, 1);
    run(0, 1, 2, 9, 1, 1, 0, 3, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule